// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit-Manipulation Unit

This unit runs the second-page bit-manipulation operations of an 8-bit processor datapath. It takes one operand byte, the opcode byte that follows the prefix, and the present carry flag. It returns the new operand value together with the new carry, the status flags, and two enables that tell the register file and the flag register whether to take them. The opcode selects one of four classes: rotate/shift, bit test, bit clear or bit set. A rotate or shift goes either through the carry or around it, and a shift is either arithmetic or logical. The three bit operations act on one bit, chosen by a bit index in the opcode.

The unit does no operand fetch. It passes the opcode's low register field out unchanged and raises a separate indication when that field names the memory operand. The surrounding sequencer uses these to pick where the operand comes from and where the result goes. A parameter decides whether the results are registered once or sent straight through.

Top module: `rsb_unit`

## Requirements
- R1: Opcode bits 7:6 select the class: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. Bits 5:3 hold the shift code or the bit index, and bits 2:0 hold the register field.
- R2: Shift code 000 rotates left and copies the old bit 7 into both bit 0 and carry. Code 001 rotates right and copies the old bit 0 into both bit 7 and carry.
- R3: Code 010 rotates left through carry: the old carry enters bit 0 and the old bit 7 becomes carry. Code 011 rotates right through carry: the old carry enters bit 7 and the old bit 0 becomes carry.
- R4: Code 100 shifts left and fills bit 0 with 0. Code 111 shifts right and fills bit 7 with 0. Code 101 shifts right and keeps bit 7. The bit shifted out becomes carry in all three.
- R5: A valid rotate/shift asserts both the result write and the flag write. Sign is set to result bit 7, zero is set when the result is 0, and parity/overflow is 1 when the result has an even number of ones. Half-carry and subtract are 0.
- R6: Shift code 110 raises the illegal indication. Neither write enable is asserted, the result equals the operand and carry out equals carry in.
- R7: Bit test writes flags but not the result. Zero is the inverse of the tested bit and parity/overflow equals zero. Sign is set only when index 7 is tested and that bit is 1. Half-carry is 1, subtract is 0, and carry out equals carry in.
- R8: Bit clear and bit set return the operand with the indexed bit forced to 0 or to 1. They assert the result write but not the flag write, and carry out equals carry in.
- R9: The register field is output unchanged, and the memory indication is 1 exactly when that field is 110.
- R10: With registered outputs, results and out_valid appear one clock after the input. Reset clears out_valid and both write enables. Without registering, they follow the inputs in the same cycle.
- R11: When in_valid is 0, neither write enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| operand | input | 8 | Operand byte |
| opcode | input | 8 | Opcode byte following the prefix |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Outputs carry a result |
| result | output | 8 | New operand value |
| wr_en | output | 1 | Write result back |
| flag_we | output | 1 | Update flags |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_h | output | 1 | Half-carry flag |
| flag_pv | output | 1 | Parity/overflow flag |
| flag_n | output | 1 | Subtract flag |
| carry_out | output | 1 | New carry flag |
| reg_code | output | 3 | Register field of the opcode |
| mem_sel | output | 1 | Register field names the memory operand |
| illegal | output | 1 | Undefined shift code |

## Verification
The bench builds two copies with the default data width. One has REG_OUT=1 and the other REG_OUT=0, so both the registered output path and the pass-through path are compared against the same behavioural model. Every one of the 256 opcodes is swept with both carry values and with operands that have bit 7 or bit 0 set, are all zeros or are all ones. This covers the bits entering and leaving at both ends, every bit index, and the illegal code. Random vectors with gaps in in_valid then exercise the write gating and the one-cycle delay of the registered variant.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   // Operation class held in the two top opcode bits
   typedef enum logic [1:0] {
      CLS_SHIFT = 2'b00,
      CLS_TEST  = 2'b01,
      CLS_CLR   = 2'b10,
      CLS_SET   = 2'b11
   } rsb_cls_e;

   // Shift codes inside the rotate/shift class
   typedef enum logic [2:0] {
      SH_RLC = 3'd0,
      SH_RRC = 3'd1,
      SH_RL  = 3'd2,
      SH_RR  = 3'd3,
      SH_SLA = 3'd4,
      SH_SRA = 3'd5,
      SH_BAD = 3'd6,
      SH_SRL = 3'd7
   } rsb_sh_e;

endpackage

// File: rtl/rsb_decode.sv
module rsb_decode
   import rsb_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter int REG_W    = 3,
   parameter int OPC_W    = 2 + IDX_W + REG_W,
   parameter logic [REG_W-1:0] MEM_CODE = 3'b110
) (
   input  logic [OPC_W-1:0] opcode,
   output rsb_cls_e         cls,
   output logic [IDX_W-1:0] field,
   output logic [REG_W-1:0] reg_code,
   output logic             mem_sel,
   output logic             illegal
);
   logic hi_bits;

   assign cls      = rsb_cls_e'(opcode[OPC_W-1 -: 2]);
   assign field    = opcode[REG_W +: IDX_W];
   assign reg_code = opcode[REG_W-1:0];
   assign mem_sel  = (reg_code == MEM_CODE);

   // Shift codes above the eight defined ones exist only for wide data
   generate
      if (IDX_W > 3) begin : g_wide
         assign hi_bits = |field[IDX_W-1:3];
      end else begin : g_narrow
         assign hi_bits = 1'b0;
      end
   endgenerate

   assign illegal = (cls == CLS_SHIFT) &&
                    ((field == IDX_W'(SH_BAD)) || hi_bits);
endmodule

// File: rtl/rsb_shifter.sv
module rsb_shifter
   import rsb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] opnd,
   input  logic [IDX_W-1:0]  code,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      res  = opnd;
      cout = cin;
      case (code)
         IDX_W'(SH_RLC): begin res = {opnd[MSB-1:0], opnd[MSB]}; cout = opnd[MSB]; end
         IDX_W'(SH_RRC): begin res = {opnd[0], opnd[MSB:1]};     cout = opnd[0];   end
         IDX_W'(SH_RL):  begin res = {opnd[MSB-1:0], cin};       cout = opnd[MSB]; end
         IDX_W'(SH_RR):  begin res = {cin, opnd[MSB:1]};         cout = opnd[0];   end
         IDX_W'(SH_SLA): begin res = {opnd[MSB-1:0], 1'b0};      cout = opnd[MSB]; end
         IDX_W'(SH_SRA): begin res = {opnd[MSB], opnd[MSB:1]};   cout = opnd[0];   end
         IDX_W'(SH_SRL): begin res = {1'b0, opnd[MSB:1]};        cout = opnd[0];   end
         default:        begin res = opnd;                       cout = cin;       end
      endcase
   end
endmodule

// File: rtl/rsb_bitops.sv
module rsb_bitops #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] opnd,
   input  logic [IDX_W-1:0]  idx,
   output logic              bit_val,
   output logic [DATA_W-1:0] cleared,
   output logic [DATA_W-1:0] setted
);
   logic [DATA_W-1:0] mask;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         assign mask[i] = (idx == IDX_W'(i));
      end
   endgenerate

   assign bit_val = |(opnd & mask);
   assign cleared = opnd & ~mask;
   assign setted  = opnd | mask;
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
   import rsb_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int REG_W   = 3,
   parameter bit REG_OUT = 1'b1,
   parameter logic [REG_W-1:0] MEM_CODE = 3'b110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] operand,
   input  logic [2+$clog2(DATA_W)+REG_W-1:0] opcode,
   input  logic              carry_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              flag_we,
   output logic              flag_s,
   output logic              flag_z,
   output logic              flag_h,
   output logic              flag_pv,
   output logic              flag_n,
   output logic              carry_out,
   output logic [REG_W-1:0]  reg_code,
   output logic              mem_sel,
   output logic              illegal
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam int OPC_W = 2 + IDX_W + REG_W;

   generate
      if ((1 << IDX_W) != DATA_W) begin : g_chk_w
         $error("rsb_unit: DATA_W must be a power of two");
      end
      if (REG_W < 1) begin : g_chk_r
         $error("rsb_unit: REG_W must be at least one");
      end
   endgenerate

   typedef struct packed {
      logic              vld;
      logic              wr;
      logic              fwe;
      logic              ill;
      logic              mem;
      logic [REG_W-1:0]  rc;
      logic [DATA_W-1:0] res;
      logic              co;
      logic              s;
      logic              z;
      logic              h;
      logic              pv;
      logic              n;
   } rsb_out_t;

   rsb_cls_e          cls;
   logic [IDX_W-1:0]  field;
   logic [REG_W-1:0]  rc;
   logic              mem, ill;
   logic [DATA_W-1:0] sh_res, clr_res, set_res;
   logic              sh_c, tbit;
   rsb_out_t          nx, q;

   rsb_decode #(.IDX_W(IDX_W), .REG_W(REG_W), .OPC_W(OPC_W), .MEM_CODE(MEM_CODE)) u_dec (
      .opcode(opcode), .cls(cls), .field(field), .reg_code(rc),
      .mem_sel(mem), .illegal(ill)
   );

   rsb_shifter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sh (
      .opnd(operand), .code(field), .cin(carry_in), .res(sh_res), .cout(sh_c)
   );

   rsb_bitops #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit (
      .opnd(operand), .idx(field), .bit_val(tbit),
      .cleared(clr_res), .setted(set_res)
   );

   always_comb begin
      nx     = '0;
      nx.vld = in_valid;
      nx.rc  = rc;
      nx.mem = mem;
      nx.res = operand;
      nx.co  = carry_in;
      unique case (cls)
         CLS_SHIFT: begin
            if (ill) begin
               nx.ill = 1'b1;
            end else begin
               nx.res = sh_res;
               nx.co  = sh_c;
               nx.wr  = in_valid;
               nx.fwe = in_valid;
               nx.s   = sh_res[DATA_W-1];
               nx.z   = (sh_res == '0);
               nx.pv  = ~^sh_res;
            end
         end
         CLS_TEST: begin
            nx.fwe = in_valid;
            nx.z   = ~tbit;
            nx.pv  = ~tbit;
            nx.h   = 1'b1;
            nx.s   = tbit && (field == IDX_W'(DATA_W - 1));
         end
         CLS_CLR: begin
            nx.res = clr_res;
            nx.wr  = in_valid;
         end
         CLS_SET: begin
            nx.res = set_res;
            nx.wr  = in_valid;
         end
         default: ;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (in_valid) begin
               q <= nx;
            end else begin
               q.vld <= 1'b0;
               q.wr  <= 1'b0;
               q.fwe <= 1'b0;
            end
         end

         // R10: a request shows up on the outputs exactly one clock later
         p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         p_idle_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
      end else begin : g_comb
         assign q = nx;
      end
   endgenerate

   assign out_valid = q.vld;
   assign result    = q.res;
   assign wr_en     = q.wr;
   assign flag_we   = q.fwe;
   assign flag_s    = q.s;
   assign flag_z    = q.z;
   assign flag_h    = q.h;
   assign flag_pv   = q.pv;
   assign flag_n    = q.n;
   assign carry_out = q.co;
   assign reg_code  = q.rc;
   assign mem_sel   = q.mem;
   assign illegal   = q.ill;

   // R11: no write of any kind without a valid output
   p_write_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || flag_we) |-> out_valid);
   // R6: an undefined shift code never writes
   p_illegal_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && illegal) |-> (!wr_en && !flag_we));
   // R7: half-carry set only by a bit test, which never writes the result
   p_test_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && flag_h) |-> (flag_we && !wr_en));
   // R8: a legal operation that leaves the flags alone is a clear or set and writes
   p_clrset_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !illegal && !flag_we) |-> wr_en);
endmodule

// File: tb/tb_rsb_unit.sv
module tb_rsb_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic       vld;
      logic       wr;
      logic       fwe;
      logic       ill;
      logic       mem;
      logic [2:0] rc;
      logic [7:0] res;
      logic       co;
      logic       s;
      logic       z;
      logic       h;
      logic       pv;
      logic       n;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] operand = 8'h00;
   logic [7:0] opcode = 8'h00;
   logic       carry_in = 1'b0;

   logic       r_vld, r_wr, r_fwe, r_s, r_z, r_h, r_pv, r_n, r_co, r_mem, r_ill;
   logic [7:0] r_res;
   logic [2:0] r_rc;
   logic       c_vld, c_wr, c_fwe, c_s, c_z, c_h, c_pv, c_n, c_co, c_mem, c_ill;
   logic [7:0] c_res;
   logic [2:0] c_rc;

   int checks = 0;
   int failures = 0;
   exp_t  exp_q = '0;
   string tag_q = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   rsb_unit #(.REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
      .opcode(opcode), .carry_in(carry_in), .out_valid(r_vld), .result(r_res),
      .wr_en(r_wr), .flag_we(r_fwe), .flag_s(r_s), .flag_z(r_z), .flag_h(r_h),
      .flag_pv(r_pv), .flag_n(r_n), .carry_out(r_co), .reg_code(r_rc),
      .mem_sel(r_mem), .illegal(r_ill)
   );

   rsb_unit #(.REG_OUT(1'b0)) dut_c (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
      .opcode(opcode), .carry_in(carry_in), .out_valid(c_vld), .result(c_res),
      .wr_en(c_wr), .flag_we(c_fwe), .flag_s(c_s), .flag_z(c_z), .flag_h(c_h),
      .flag_pv(c_pv), .flag_n(c_n), .carry_out(c_co), .reg_code(c_rc),
      .mem_sel(c_mem), .illegal(c_ill)
   );

   // Behavioural reference
   function automatic exp_t model(input logic v, input logic [7:0] a,
                                  input logic [7:0] opc, input logic c);
      exp_t e;
      int x, r, co, f, ones;
      e = '0;
      x = int'(a);
      f = int'(opc[5:3]);
      r = x;
      co = int'(c);
      e.vld = v;
      e.rc  = opc[2:0];
      e.mem = (opc[2:0] == 3'd6);
      case (opc[7:6])
         2'd0: begin
            case (f)
               0: begin r = ((x << 1) | (x >> 7)) & 255; co = (x >> 7) & 1; end
               1: begin r = (x >> 1) | ((x & 1) << 7);   co = x & 1; end
               2: begin r = ((x << 1) & 255) | int'(c);  co = (x >> 7) & 1; end
               3: begin r = (x >> 1) | (int'(c) << 7);   co = x & 1; end
               4: begin r = (x << 1) & 255;              co = (x >> 7) & 1; end
               5: begin r = (x >> 1) | (x & 128);        co = x & 1; end
               7: begin r = x >> 1;                      co = x & 1; end
               default: e.ill = 1'b1;
            endcase
            if (!e.ill) begin
               ones = 0;
               for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
               e.wr  = v;
               e.fwe = v;
               e.s   = (r >= 128);
               e.z   = (r == 0);
               e.pv  = (ones % 2 == 0);
            end
         end
         2'd1: begin
            e.fwe = v;
            e.z   = (((x >> f) & 1) == 0);
            e.pv  = e.z;
            e.h   = 1'b1;
            e.s   = (f == 7) && !e.z;
         end
         2'd2: begin r = x & ~(1 << f) & 255; e.wr = v; end
         default: begin r = (x | (1 << f)) & 255; e.wr = v; end
      endcase
      e.res = 8'(r);
      e.co  = co[0];
      return e;
   endfunction

   function automatic string tag_of(input logic v, input logic [7:0] opc);
      if (!v) return "R11";
      case (opc[7:6])
         2'd0: case (opc[5:3])
                  3'd0, 3'd1: return "R1 R2 R5";
                  3'd2, 3'd3: return "R1 R3 R5";
                  3'd6:       return "R1 R6";
                  default:    return "R1 R4 R5";
               endcase
         2'd1:    return "R1 R7";
         default: return "R1 R8";
      endcase
   endfunction

   task automatic check(input string who, input string tag, input exp_t act,
                        input exp_t e, input bit full);
      bit bad;
      checks++;
      if (full) bad = (act !== e);
      else bad = ({act.vld, act.wr, act.fwe} !== {e.vld, e.wr, e.fwe});
      if (bad) begin
         failures++;
         $display("FAIL %s [%s] actual=%h expected=%h", who, tag, act, e);
      end
   endtask

   function automatic exp_t act_r();
      return '{r_vld, r_wr, r_fwe, r_ill, r_mem, r_rc, r_res, r_co, r_s, r_z, r_h, r_pv, r_n};
   endfunction
   function automatic exp_t act_c();
      return '{c_vld, c_wr, c_fwe, c_ill, c_mem, c_rc, c_res, c_co, c_s, c_z, c_h, c_pv, c_n};
   endfunction

   task automatic step(input logic v, input logic [7:0] a, input logic [7:0] opc,
                       input logic c);
      exp_t e;
      @(negedge clk);
      // R10: registered copy shows the previous cycle's request
      check("registered", {tag_q, " R10"}, act_r(), exp_q, exp_q.vld);
      in_valid = v;
      operand  = a;
      opcode   = opc;
      carry_in = c;
      #1;
      e = model(v, a, opc, c);
      check("pass-through", tag_of(v, opc), act_c(), e, v);
      // R9: register field and memory indication
      checks++;
      if ({c_rc, c_mem} !== {opc[2:0], opc[2:0] == 3'd6}) begin
         failures++;
         $display("FAIL pass-through [R9] actual=%b%b expected=%b%b",
                  c_rc, c_mem, opc[2:0], opc[2:0] == 3'd6);
      end
      exp_q = e;
      tag_q = tag_of(v, opc);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog [R10] actual=running expected=finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state of the registered copy
      checks++;
      if ({r_vld, r_wr, r_fwe} !== 3'b000) begin
         failures++;
         $display("FAIL reset [R10] actual=%b expected=000", {r_vld, r_wr, r_fwe});
      end
      rst_n = 1'b1;
      // Corner cases: R2 rotate of 0x80, R4 arithmetic shift of 0x80,
      // R3 rotate right through carry of 0x01, R7 test of bit 7
      step(1'b1, 8'h80, 8'h00, 1'b0);
      step(1'b1, 8'h80, 8'h28, 1'b0);
      step(1'b1, 8'h01, 8'h19, 1'b1);
      step(1'b1, 8'h80, 8'h7E, 1'b0);
      step(1'b1, 8'h12, 8'h30, 1'b1);   // R6 illegal code
      step(1'b0, 8'h55, 8'hC0, 1'b0);   // R11 idle cycle
      // Full opcode sweep with several operands and both carries
      for (int k = 0; k < 5; k++) begin
         for (int op = 0; op < 256; op++) begin
            logic [7:0] a;
            case (k)
               0: a = 8'h96;
               1: a = 8'h00;
               2: a = 8'hFF;
               3: a = 8'h81;
               default: a = 8'h7E;
            endcase
            step(1'b1, a, 8'(op), k[0]);
         end
      end
      // Random traffic with idle gaps
      for (int n = 0; n < 600; n++) begin
         step(($urandom % 4) != 0, 8'($urandom), 8'($urandom), 1'($urandom));
      end
      step(1'b0, 8'h00, 8'h00, 1'b0);
      step(1'b0, 8'h00, 8'h00, 1'b0);
      report();
   end
endmodule